// File: doc/BRIEF.md
# Branch Target Line Cache

This block is a small fully-associative cache placed between an instruction fetch unit and a slow flash array with a 15-bit byte address space. Each of its 32 entries keeps a valid flag, a 13-bit line tag (address bits 14 down to 2) and one 4-byte line. A fetch whose tag matches a valid entry is answered in the same cycle with the byte chosen by address bits 1:0. A fetch that misses is forwarded to the flash port as a line request, and the fetch unit is stalled until the flash hands back the whole line.

Filling is selective. The block counts how many cycles the fetch was held off, and writes the returned line into the cache only when that count is strictly greater than a 2-bit programmable threshold. This keeps short, cheap misses from evicting useful lines. The entry to overwrite comes either from a pointer that sweeps up and down the array or from a 5-bit linear feedback shift register; a mode input picks which. A flush input empties the whole cache at once. The fetch side must hold its valid and address steady while it is stalled.

Top module: `btc_cache`

## Requirements
- R1: When the fetch tag matches a valid entry, `fetch_ready` rises in the request cycle, no flash request is made, and `fetch_data` is byte k of the stored line, where k is `fetch_addr[1:0]` and byte k occupies bits 8k+7:8k of the flash line word.
- R2: On a miss, `flash_req_valid` rises in the miss cycle with `flash_req_line` equal to `fetch_addr[14:2]`, and both hold until `flash_req_ready` is seen; `fetch_ready` stays low until the cycle `flash_rsp_valid` is high, and in that cycle it is high with the selected byte of `flash_rsp_data`.
- R3: The stall count is the number of cycles `fetch_ready` was low for the miss, from the miss cycle up to the response cycle; the line is written only if that count is greater than `miss_thresh` (with threshold 2, stalls of 1 or 2 cycles are not kept, stalls of 3 or 4 are).
- R4: With `miss_thresh` at 0, every completed miss is kept.
- R5: With `repl_random` at 0, victims follow 0, 1, ..., 31, 30, ..., 1, 0, 1, ... without repeating an end entry; the pointer moves only on a fill.
- R6: With `repl_random` at 1, the victim is the current state of a 5-bit LFSR (shift toward the MSB, new LSB = bit4 XOR bit2, reset value 1); the LFSR and the sweep pointer both advance on every fill whatever the mode.
- R7: A high `flush` in a cycle invalidates every entry from the next cycle on, and a fill in that same cycle is dropped.
- R8: After reset every entry is invalid, and with `fetch_valid` low both `fetch_ready` and `flash_req_valid` are low.
- R9: The stall counter saturates at 7 rather than wrapping, so a very long stall is kept even at the largest threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 15 | Byte address of the fetch |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_data | output | 8 | Returned byte |
| flush | input | 1 | Invalidate all entries |
| repl_random | input | 1 | 0: sweep victim order, 1: LFSR victim |
| miss_thresh | input | 2 | Minimum stall, exclusive, for a fill |
| flash_req_valid | output | 1 | Line request to flash |
| flash_req_ready | input | 1 | Flash accepts the request |
| flash_req_line | output | 13 | Requested line address |
| flash_rsp_valid | input | 1 | Flash line data present |
| flash_rsp_data | input | 32 | Flash line, byte k at bits 8k+7:8k |

## Verification
The hardest state to reach is the turn of the sweep pointer at the top of the array, since it needs 32 kept fills before the 33rd shows where the pointer went; the bench fills 33 distinct lines at threshold 0 and then probes which of the most recent lines were evicted, checking survivors before the first miss that would itself refill. Mixing of the two victim sources is reached by filling under the LFSR and then switching back to the sweep, so that the landing slot of a later line exposes how far the shared pointer moved. Threshold edges are reached by timing the flash response, and by delaying the request handshake, so the stall count lands exactly on and beside each threshold.

// File: rtl/btc_pkg.sv
`timescale 1ns/1ps
package btc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } btc_state_e;

  // Feedback tap masks of maximal-length Fibonacci LFSRs, indexed by width.
  function automatic logic [7:0] lfsr_taps(input int unsigned width);
    case (width)
      2:       return 8'h03;
      3:       return 8'h06;
      4:       return 8'h0C;
      5:       return 8'h14;
      6:       return 8'h30;
      7:       return 8'h60;
      default: return 8'hB8;
    endcase
  endfunction

endpackage

// File: rtl/btc_tag_array.sv
`timescale 1ns/1ps
module btc_tag_array #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned TAG_W   = 13,
  parameter int unsigned IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [TAG_W-1:0] lookup_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      tag_q[wr_idx]   <= wr_tag;
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid_q[g] && (tag_q[g] == lookup_tag);
    end
  endgenerate

  // Lowest-numbered matching entry wins.
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |match;

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

endmodule

// File: rtl/btc_data_array.sv
`timescale 1ns/1ps
module btc_data_array #(
  parameter int unsigned ENTRIES   = 32,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned SLOT_BITS = 32
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [SLOT_BITS-1:0] wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [SLOT_BITS-1:0] rd_data
);

  logic [SLOT_BITS-1:0] line_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[wr_idx] <= wr_data;
  end

  assign rd_data = line_q[rd_idx];

endmodule

// File: rtl/btc_victim.sv
`timescale 1ns/1ps
module btc_victim #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             use_random,
  output logic [IDX_W-1:0] victim
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  localparam logic [7:0]       TAPS = btc_pkg::lfsr_taps(IDX_W);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             up_q, up_d;
  logic [IDX_W-1:0] lfsr_q;

  function automatic logic [IDX_W-1:0] lfsr_next(input logic [IDX_W-1:0] q);
    return {q[IDX_W-2:0], ^(q & TAPS[IDX_W-1:0])};
  endfunction

  // Sweep up to the last entry, then back down, never repeating an end.
  always_comb begin
    ptr_d = ptr_q;
    up_d  = up_q;
    if (up_q) begin
      if (ptr_q == LAST) begin
        ptr_d = LAST - IDX_W'(1);
        up_d  = 1'b0;
      end else begin
        ptr_d = ptr_q + IDX_W'(1);
      end
    end else begin
      if (ptr_q == '0) begin
        ptr_d = IDX_W'(1);
        up_d  = 1'b1;
      end else begin
        ptr_d = ptr_q - IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      up_q   <= 1'b1;
      lfsr_q <= IDX_W'(1);
    end else if (step) begin
      ptr_q  <= ptr_d;
      up_q   <= up_d;
      lfsr_q <= lfsr_next(lfsr_q);
    end
  end

  assign victim = use_random ? lfsr_q : ptr_q;

  a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  a_r5_sweep_moves_one: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((ptr_q == $past(ptr_q) + IDX_W'(1)) || (ptr_q == $past(ptr_q) - IDX_W'(1))));

  a_r5_sweep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr_q));

endmodule

// File: rtl/btc_miss_ctrl.sv
`timescale 1ns/1ps
module btc_miss_ctrl #(
  parameter int unsigned TAG_W   = 13,
  parameter int unsigned THR_W   = 2,
  parameter int unsigned STALL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic             lookup_hit,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic             flush,
  input  logic [THR_W-1:0] thresh,
  input  logic             flash_req_ready,
  input  logic             flash_rsp_valid,
  output logic             flash_req_valid,
  output logic [TAG_W-1:0] flash_req_line,
  output logic             idle,
  output logic             resp_done,
  output logic             fill_en,
  output logic [TAG_W-1:0] fill_tag
);

  import btc_pkg::*;

  localparam logic [STALL_W-1:0] STALL_MAX = {STALL_W{1'b1}};

  btc_state_e       state_q;
  logic [TAG_W-1:0] line_q;
  logic [STALL_W-1:0] stall_q;
  logic             miss_start;

  function automatic logic [STALL_W-1:0] sat_inc(input logic [STALL_W-1:0] v);
    return (v == STALL_MAX) ? v : v + STALL_W'(1);
  endfunction

  function automatic logic keep_line(input logic [STALL_W-1:0] s,
                                     input logic [THR_W-1:0] t);
    return s > STALL_W'(t);
  endfunction

  assign idle            = (state_q == ST_IDLE);
  assign miss_start      = idle && fetch_valid && !lookup_hit;
  assign flash_req_valid = miss_start || (state_q == ST_REQ);
  assign flash_req_line  = idle ? fetch_tag : line_q;
  assign resp_done       = (state_q == ST_WAIT) && flash_rsp_valid;
  assign fill_en         = resp_done && keep_line(stall_q, thresh) && !flush;
  assign fill_tag        = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      stall_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (miss_start) begin
            line_q  <= fetch_tag;
            stall_q <= STALL_W'(1);
            state_q <= flash_req_ready ? ST_WAIT : ST_REQ;
          end
        end
        ST_REQ: begin
          stall_q <= sat_inc(stall_q);
          if (flash_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (flash_rsp_valid) begin
            stall_q <= '0;
            state_q <= ST_IDLE;
          end else begin
            stall_q <= sat_inc(stall_q);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_req_valid && !flash_req_ready) |=> (flash_req_valid && $stable(flash_req_line)));

  a_r9_stall_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ((stall_q == STALL_MAX) && !idle && !resp_done) |=> (stall_q == STALL_MAX));

endmodule

// File: rtl/btc_cache.sv
`timescale 1ns/1ps
module btc_cache #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned SLOT_BYTES = 4,
  parameter int unsigned ENTRIES    = 32,
  parameter int unsigned THR_W      = 2,
  parameter int unsigned STALL_W    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fetch_valid,
  input  logic [ADDR_W-1:0]            fetch_addr,
  output logic                         fetch_ready,
  output logic [7:0]                   fetch_data,
  input  logic                         flush,
  input  logic                         repl_random,
  input  logic [THR_W-1:0]             miss_thresh,
  output logic                         flash_req_valid,
  input  logic                         flash_req_ready,
  output logic [ADDR_W-$clog2(SLOT_BYTES)-1:0] flash_req_line,
  input  logic                         flash_rsp_valid,
  input  logic [8*SLOT_BYTES-1:0]      flash_rsp_data
);

  localparam int unsigned OFF_W     = $clog2(SLOT_BYTES);
  localparam int unsigned TAG_W     = ADDR_W - OFF_W;
  localparam int unsigned IDX_W     = $clog2(ENTRIES);
  localparam int unsigned SLOT_BITS = 8 * SLOT_BYTES;

  logic [TAG_W-1:0]     fetch_tag;
  logic [OFF_W-1:0]     fetch_off;
  logic                 tag_hit;
  logic [IDX_W-1:0]     hit_idx;
  logic                 ctrl_idle;
  logic                 resp_done;
  logic                 fill_en;
  logic [TAG_W-1:0]     fill_tag;
  logic [IDX_W-1:0]     victim;
  logic [SLOT_BITS-1:0] stored_line;
  logic                 hit_now;

  function automatic logic [7:0] pick_byte(input logic [SLOT_BITS-1:0] line,
                                           input logic [OFF_W-1:0] off);
    return line[8*off +: 8];
  endfunction

  assign fetch_tag = fetch_addr[ADDR_W-1:OFF_W];
  assign fetch_off = fetch_addr[OFF_W-1:0];

  btc_tag_array #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .IDX_W   (IDX_W)
  ) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lookup_tag (fetch_tag),
    .wr_en      (fill_en),
    .wr_idx     (victim),
    .wr_tag     (fill_tag),
    .hit        (tag_hit),
    .hit_idx    (hit_idx)
  );

  btc_data_array #(
    .ENTRIES   (ENTRIES),
    .IDX_W     (IDX_W),
    .SLOT_BITS (SLOT_BITS)
  ) u_data (
    .clk     (clk),
    .wr_en   (fill_en),
    .wr_idx  (victim),
    .wr_data (flash_rsp_data),
    .rd_idx  (hit_idx),
    .rd_data (stored_line)
  );

  btc_victim #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (fill_en),
    .use_random (repl_random),
    .victim     (victim)
  );

  btc_miss_ctrl #(
    .TAG_W   (TAG_W),
    .THR_W   (THR_W),
    .STALL_W (STALL_W)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_valid     (fetch_valid),
    .lookup_hit      (tag_hit),
    .fetch_tag       (fetch_tag),
    .flush           (flush),
    .thresh          (miss_thresh),
    .flash_req_ready (flash_req_ready),
    .flash_rsp_valid (flash_rsp_valid),
    .flash_req_valid (flash_req_valid),
    .flash_req_line  (flash_req_line),
    .idle            (ctrl_idle),
    .resp_done       (resp_done),
    .fill_en         (fill_en),
    .fill_tag        (fill_tag)
  );

  assign hit_now     = ctrl_idle && fetch_valid && tag_hit;
  assign fetch_ready = hit_now || resp_done;
  assign fetch_data  = resp_done ? pick_byte(flash_rsp_data, fetch_off)
                                 : pick_byte(stored_line, fetch_off);

  a_r1_hit_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |-> !flash_req_valid);

  a_r3_fill_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> $past(!fetch_ready));

  a_r8_quiet_without_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && ctrl_idle) |-> (!fetch_ready && !flash_req_valid));

endmodule

// File: tb/tb_btc_cache.sv
`timescale 1ns/1ps
module tb_btc_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [14:0] fetch_addr = '0;
  logic        fetch_ready;
  logic [7:0]  fetch_data;
  logic        flush = 1'b0;
  logic        repl_random = 1'b0;
  logic [1:0]  miss_thresh = 2'd0;
  logic        flash_req_valid;
  logic        flash_req_ready = 1'b0;
  logic [12:0] flash_req_line;
  logic        flash_rsp_valid = 1'b0;
  logic [31:0] flash_rsp_data = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  btc_cache dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_valid     (fetch_valid),
    .fetch_addr      (fetch_addr),
    .fetch_ready     (fetch_ready),
    .fetch_data      (fetch_data),
    .flush           (flush),
    .repl_random     (repl_random),
    .miss_thresh     (miss_thresh),
    .flash_req_valid (flash_req_valid),
    .flash_req_ready (flash_req_ready),
    .flash_req_line  (flash_req_line),
    .flash_rsp_valid (flash_rsp_valid),
    .flash_rsp_data  (flash_rsp_data)
  );

  // {threshold, response latency, expected kept}
  localparam logic [7:0] VECS [10] = '{
    {2'd0, 5'd1,  1'b1},
    {2'd1, 5'd1,  1'b0},
    {2'd1, 5'd2,  1'b1},
    {2'd2, 5'd1,  1'b0},
    {2'd2, 5'd2,  1'b0},
    {2'd2, 5'd3,  1'b1},
    {2'd2, 5'd4,  1'b1},
    {2'd3, 5'd3,  1'b0},
    {2'd3, 5'd4,  1'b1},
    {2'd3, 5'd12, 1'b1}
  };

  function automatic logic [31:0] word_of(input logic [12:0] line);
    return {line[7:0] ^ 8'h5A, {3'b101, line[12:8]}, ~line[7:0], line[7:0] + 8'd29};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fetch_valid = 1'b0; flush = 1'b0; flash_req_ready = 1'b0;
    flash_rsp_valid = 1'b0; repl_random = 1'b0; miss_thresh = 2'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  // Entered and left one time unit after a rising edge.
  task automatic do_fetch(input logic [14:0] a, input int req_dly, input int lat,
                          input bit flush_rsp, input string req,
                          output bit hit, output logic [7:0] d);
    logic [31:0] w;
    w = word_of(a[14:2]);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    #1;
    if (fetch_ready) begin
      hit = 1'b1;
      d   = fetch_data;
      check(!flash_req_valid, "R1", "flash request during hit", flash_req_valid, 0);
      @(posedge clk); #1;
      fetch_valid = 1'b0;
    end else begin
      hit = 1'b0;
      check(flash_req_valid && flash_req_line == a[14:2], "R2", "miss request line",
            flash_req_line, a[14:2]);
      for (int i = 0; i < req_dly; i++) begin
        @(posedge clk); #1;
        check(flash_req_valid && flash_req_line == a[14:2] && !fetch_ready, "R2",
              "request held while not accepted", flash_req_valid, 1);
      end
      flash_req_ready = 1'b1;
      @(posedge clk); #1;
      flash_req_ready = 1'b0;
      for (int i = 1; i < lat; i++) begin
        check(!fetch_ready, "R2", "ready low while waiting", fetch_ready, 0);
        @(posedge clk); #1;
      end
      flash_rsp_valid = 1'b1;
      flash_rsp_data  = w;
      flush = flush_rsp;
      #1;
      d = fetch_data;
      check(fetch_ready && d == w[8*a[1:0] +: 8], "R2", "response byte", d, w[8*a[1:0] +: 8]);
      @(posedge clk); #1;
      flash_rsp_valid = 1'b0;
      flush = 1'b0;
      fetch_valid = 1'b0;
    end
  endtask

  task automatic probe(input logic [14:0] a, input bit exp_hit, input string req);
    bit h;
    logic [7:0] d;
    logic [31:0] w;
    w = word_of(a[14:2]);
    do_fetch(a, 0, 1, 1'b0, req, h, d);
    check(h == exp_hit, req, "hit state", h, exp_hit);
    if (h) check(d == w[8*a[1:0] +: 8], req, "hit byte", d, w[8*a[1:0] +: 8]);
  endtask

  task automatic fill(input logic [12:0] line);
    bit h;
    logic [7:0] d;
    do_fetch({line, 2'b00}, 0, 1, 1'b0, "R4", h, d);
  endtask

  initial begin
    bit h;
    logic [7:0] d;

    // R8: reset state
    do_reset();
    check(!fetch_ready && !flash_req_valid, "R8", "outputs idle after reset",
          {fetch_ready, flash_req_valid}, 0);
    probe({13'h0077, 2'b01}, 1'b0, "R8");

    // R3, R4, R9: threshold vectors
    for (int i = 0; i < 10; i++) begin
      logic [14:0] a;
      a = {13'h0100 + 13'(i), 2'b10};
      miss_thresh = VECS[i][7:6];
      do_fetch(a, 0, int'(VECS[i][5:1]), 1'b0, "R3", h, d);
      check(!h, "R3", "vector starts with miss", h, 0);
      miss_thresh = 2'd3;
      probe(a, VECS[i][0], (i == 0) ? "R4" : ((i == 9) ? "R9" : "R3"));
    end

    // R3: request handshake delay counts toward the stall
    miss_thresh = 2'd2;
    do_fetch({13'h0180, 2'b00}, 2, 1, 1'b0, "R3", h, d);
    miss_thresh = 2'd3;
    probe({13'h0180, 2'b00}, 1'b1, "R3");

    // R1: byte selection on hits
    do_reset();
    fill(13'h0055);
    for (int k = 0; k < 4; k++) probe({13'h0055, 2'(k)}, 1'b1, "R1");

    // R5: sweep order with turn at the top, no move on a dropped miss
    do_reset();
    miss_thresh = 2'd3;
    do_fetch({13'h0999, 2'b00}, 0, 1, 1'b0, "R5", h, d);
    miss_thresh = 2'd0;
    for (int i = 0; i < 33; i++) fill(13'h0400 + 13'(i));
    probe({13'h0400 + 13'd31, 2'b00}, 1'b1, "R5");
    probe({13'h0400 + 13'd29, 2'b11}, 1'b1, "R5");
    probe({13'h0400, 2'b00}, 1'b1, "R5");
    probe({13'h0400 + 13'd32, 2'b01}, 1'b1, "R5");
    probe({13'h0400 + 13'd30, 2'b00}, 1'b0, "R5");
    probe({13'h0400 + 13'd28, 2'b00}, 1'b1, "R5");
    probe({13'h0400 + 13'd29, 2'b00}, 1'b0, "R5");

    // R6: LFSR victims 1, 2, 4, then sweep resumes at 3
    do_reset();
    repl_random = 1'b1;
    fill(13'h0A01); fill(13'h0A02); fill(13'h0A03);
    repl_random = 1'b0;
    fill(13'h0A04); fill(13'h0A05);
    probe({13'h0A01, 2'b00}, 1'b1, "R6");
    probe({13'h0A02, 2'b00}, 1'b1, "R6");
    probe({13'h0A04, 2'b00}, 1'b1, "R6");
    probe({13'h0A05, 2'b00}, 1'b1, "R6");
    probe({13'h0A03, 2'b00}, 1'b0, "R6");

    // R7: flush empties, flush beats a fill
    do_reset();
    fill(13'h0B01); fill(13'h0B02);
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
    check(!flash_req_valid, "R7", "idle after flush", flash_req_valid, 0);
    probe({13'h0B01, 2'b00}, 1'b0, "R7");
    probe({13'h0B02, 2'b00}, 1'b0, "R7");
    do_fetch({13'h0B03, 2'b00}, 0, 1, 1'b1, "R7", h, d);
    probe({13'h0B03, 2'b00}, 1'b0, "R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule